// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block is one counter channel that emits a single delayed pulse for every accepted trigger. Software first enables the channel through a small register write port. While enabled and idle, the counter sits at all-ones (or at zero after a completed pulse) and waits. A trigger is either a chosen edge on an external input or a software strobe bit in the control word. When one arrives, the counter restarts from zero and advances once per clock. The pulse output goes high when the count reaches the start compare value and stays high through the end compare value. Each compare value has its own one-cycle interrupt strobe.

The two compare values are held in software-visible shadow registers. The counter works from private copies, which are refreshed only while no pulse is in flight. Triggers that come in during the delay or the active phase have no effect. Clearing the enable bit stops the channel at once.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset the count output is all-ones, the pulse output and both interrupt strobes are low, and the channel is disabled.
- R2: While enabled and never triggered, the count output stays at all-ones and the pulse output stays low.
- R3: A control write (address 0) with bit 0 (enable) and bit 1 (software trigger) both set, made while the channel is already enabled and waiting, starts a run. The count output reads 0 in the cycle after the write edge and then rises by one per clock.
- R4: During a run the pulse output is high exactly while the count lies between the start compare value (address 2) and the end compare value (address 1), both inclusive. That gives a delay of start cycles and a width of end − start + 1 cycles. If start exceeds end, there is no pulse.
- R5: The start-match strobe is high for exactly the one cycle in which the running count equals the start compare value.
- R6: The end strobe is high for one cycle, the cycle after the count equalled the end compare value. In that same cycle the count output reads 0, and it stays at 0 while the channel waits for the next trigger.
- R7: A software trigger or an external edge that lands during the delay, during the active phase, or on the final counting cycle does not restart or extend the run.
- R8: The external trigger input passes through a two-flip-flop synchronizer. Control bits 3:2 choose the accepted edge: 0 none, 1 rising, 2 falling, 3 both. An accepted edge starts a run whose count reads 0 after the third clock edge following the input change.
- R9: A compare write made during a run does not change that run. The next run uses the new value.
- R10: A control write with enable cleared forces the count output to all-ones from the next cycle. It also drops the pulse output and both strobes at once, and no end strobe follows.
- R11: A software trigger carried in the same write that enables the channel is ignored. Edges seen on the external input while the channel is disabled are not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; the counter advances on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 end compare, 2 start compare |
| wr_data | input | CNT_W | Write data; control uses bit 0 enable, bit 1 software trigger, bits 3:2 edge select |
| trig_i | input | 1 | Asynchronous external trigger input |
| pulse_o | output | 1 | One-shot pulse, active high |
| cc0_irq_o | output | 1 | End-compare interrupt strobe |
| cc1_irq_o | output | 1 | Start-compare interrupt strobe |
| count_o | output | CNT_W | Current counter value |

## Verification
The trigger path and the end-of-run path can act in the same clock edge. A software trigger or a synchronized external edge can land exactly when the count equals the end value and the channel is about to return to waiting. The bench provokes this case on purpose. It injects a software trigger write right after the last counting sample. It also times an external toggle so that the synchronizer delivers the edge on that same closing edge. Both are judged the same way: the pulse and strobes must follow the unmodified schedule, and the count must stay at zero with no second pulse afterwards. The bench treats an enable write that also carries the software trigger bit as a second coincidence case and expects the trigger to be refused.

// File: rtl/otp_pkg.sv
// Shared encodings for the one-shot pulse timer: register addresses,
// control field positions, edge-select codes and the channel state.
// Assumes a control word of at least four bits.
package otp_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_END  = 2'd1;
    localparam logic [1:0] ADDR_BEG  = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SWT_BIT  = 1;
    localparam int CTRL_EDGE_LSB = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;
endpackage

// File: rtl/otp_regs.sv
// Register file of the one-shot timer: the enable bit, the edge select and
// the two shadow compare values. It also decodes the software trigger strobe.
// Assumes one write per cycle. A trigger counts only if the channel was
// already enabled before the write.
module otp_regs
    import otp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             enable_o,
    output edge_sel_e        edge_sel_o,
    output logic             sw_trig_o,
    output logic [CNT_W-1:0] end_sh_o,
    output logic [CNT_W-1:0] beg_sh_o
);
    logic wr_ctrl;

    // Address decode for the control word.
    always_comb wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);

    // Control fields: enable and edge select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o   <= 1'b0;
            edge_sel_o <= EDGE_NONE;
        end else if (wr_ctrl) begin
            enable_o   <= wr_data[CTRL_EN_BIT];
            edge_sel_o <= edge_sel_e'(wr_data[CTRL_EDGE_LSB +: 2]);
        end
    end

    // Shadow compare registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_sh_o <= '0;
            beg_sh_o <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_END) end_sh_o <= wr_data;
            if (wr_addr == ADDR_BEG) beg_sh_o <= wr_data;
        end
    end

    // Software trigger strobe: only honoured while already enabled and staying enabled.
    always_comb sw_trig_o = wr_ctrl && wr_data[CTRL_SWT_BIT]
                            && wr_data[CTRL_EN_BIT] && enable_o;
endmodule

// File: rtl/otp_trig.sv
// External trigger front end: a synchronizer chain followed by an edge
// detector that honours the selected polarity. It assumes trig_i is
// asynchronous to clk and that SYNC_STAGES is at least 2.
module otp_trig
    import otp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig_i,
    input  edge_sel_e edge_sel_i,
    output logic      edge_o
);
    localparam int TAPS = SYNC_STAGES + 1;

    logic [TAPS-1:0] tap;
    logic            rise;
    logic            fall;

    // Synchronizer stages plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tap <= '0;
        else        tap <= {tap[TAPS-2:0], trig_i};
    end

    // Raw edge terms from the last synchronized stage and its history.
    always_comb begin
        rise = tap[TAPS-2] & ~tap[TAPS-1];
        fall = ~tap[TAPS-2] & tap[TAPS-1];
    end

    // Polarity filter chosen by the edge-select field.
    always_comb begin
        unique case (edge_sel_i)
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/otp_core.sv
// Counter, compare buffers and output decode of the one-shot timer.
// The counter idles until start_i, counts from zero up to the end value,
// then parks at zero. Buffers follow the shadows only while not running.
// It assumes enable_i is registered and start_i is a single-cycle strobe.
module otp_core
    import otp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] end_sh_i,
    input  logic [CNT_W-1:0] beg_sh_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pulse_o,
    output logic             cc0_irq_o,
    output logic             cc1_irq_o
);
    localparam int             NUM_CMP  = 2;
    localparam logic [CNT_W-1:0] CNT_IDLE = '1;

    chan_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] shadow [NUM_CMP];
    logic [CNT_W-1:0] cmp_buf [NUM_CMP];
    logic             running;
    logic             at_end;
    logic             end_q;

    always_comb begin
        shadow[0] = end_sh_i;
        shadow[1] = beg_sh_i;
    end

    // Per-channel buffer: copy the shadow while no pulse is in flight.
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_buf
        always_ff @(posedge clk) begin
            if (!rst_n)                 cmp_buf[i] <= '0;
            else if (state != ST_RUN)   cmp_buf[i] <= shadow[i];
        end
    end

    // Status terms of the running counter.
    always_comb begin
        running = enable_i && (state == ST_RUN);
        at_end  = running && (cnt == cmp_buf[0]);
    end

    // Channel sequencing: wait, run, return to wait parked at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cnt   <= CNT_IDLE;
        end else if (!enable_i) begin
            state <= ST_WAIT;
            cnt   <= CNT_IDLE;
        end else if (state == ST_WAIT) begin
            if (start_i) begin
                state <= ST_RUN;
                cnt   <= '0;
            end
        end else if (at_end) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // End strobe registered one increment after the end match.
    always_ff @(posedge clk) begin
        if (!rst_n) end_q <= 1'b0;
        else        end_q <= at_end;
    end

    // Output decode, gated by enable so a disable takes effect immediately.
    always_comb begin
        count_o   = enable_i ? cnt : CNT_IDLE;
        pulse_o   = running && (cnt >= cmp_buf[1]) && (cnt <= cmp_buf[0]);
        cc1_irq_o = running && (cnt == cmp_buf[1]);
        cc0_irq_o = enable_i && end_q;
    end
endmodule

// File: rtl/oneshot_pulse_timer.sv
// Top of the one-shot pulse timer channel: register port, external trigger
// front end and counting core. It assumes a single clock domain; only
// trig_i is asynchronous.
module oneshot_pulse_timer
    import otp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             trig_i,
    output logic             pulse_o,
    output logic             cc0_irq_o,
    output logic             cc1_irq_o,
    output logic [CNT_W-1:0] count_o
);
    logic             enable;
    edge_sel_e        edge_sel;
    logic             sw_trig;
    logic             ext_edge;
    logic             start;
    logic [CNT_W-1:0] end_sh;
    logic [CNT_W-1:0] beg_sh;

    otp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .enable_o   (enable),
        .edge_sel_o (edge_sel),
        .sw_trig_o  (sw_trig),
        .end_sh_o   (end_sh),
        .beg_sh_o   (beg_sh)
    );

    otp_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .edge_sel_i (edge_sel),
        .edge_o     (ext_edge)
    );

    // Merge both trigger sources into one start request.
    always_comb start = sw_trig | ext_edge;

    otp_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .start_i   (start),
        .end_sh_i  (end_sh),
        .beg_sh_i  (beg_sh),
        .count_o   (count_o),
        .pulse_o   (pulse_o),
        .cc0_irq_o (cc0_irq_o),
        .cc1_irq_o (cc1_irq_o)
    );
endmodule

// File: rtl/otp_checker.sv
// Port-level temporal checks for the one-shot pulse timer, attached by bind.
// It assumes the default register encodings from otp_pkg.
module otp_checker
    import otp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             pulse_o,
    input logic             cc0_irq_o,
    input logic             cc1_irq_o,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> (count_o == CNT_W'($past(count_o) + 1'b1))
                    || (count_o == '0) || (count_o == ALL_ONES));

    // R5
    start_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc1_irq_o |-> pulse_o);

    // R6
    end_parks_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc0_irq_o |-> (count_o == '0) && !pulse_o);

    // R6
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc0_irq_o |=> !cc0_irq_o);

    // R10
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_CTRL) && !wr_data[CTRL_EN_BIT])
        |=> (count_o == ALL_ONES) && !pulse_o && !cc0_irq_o && !cc1_irq_o);
endmodule

bind oneshot_pulse_timer otp_checker #(.CNT_W(CNT_W)) u_otp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pulse_o   (pulse_o),
    .cc0_irq_o (cc0_irq_o),
    .cc1_irq_o (cc1_irq_o),
    .count_o   (count_o)
);

// File: tb/oneshot_pulse_timer_test.sv
// Self-checking bench: sweeps compare pairs, trigger sources, coincident
// triggers, buffer updates and enable handling with arithmetic expectations.
module oneshot_pulse_timer_test;
    localparam int CNT_W = 16;
    localparam int SYNC  = 2;
    localparam int IDLE1 = 65535;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             trig_in = 1'b0;
    logic             pulse;
    logic             irq0;
    logic             irq1;
    logic [CNT_W-1:0] cnt;

    int n_chk  = 0;
    int n_fail = 0;
    int idle_now = IDLE1;

    oneshot_pulse_timer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .trig_i    (trig_in),
        .pulse_o   (pulse),
        .cc0_irq_o (irq0),
        .cc1_irq_o (irq1),
        .count_o   (cnt)
    );

    always #2 clk = ~clk;

    function automatic logic [CNT_W-1:0] ctl(input bit en, input bit swt, input logic [1:0] edg);
        return CNT_W'({edg, swt, en});
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Drive one write after a falling edge; returns at the next falling edge.
    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Sample a run window; k counts edges since the starting edge.
    task automatic observe(input int c0, input int c1, input bit fired, input int idle,
                           input int inj_k, input bit inj_ext, input logic [CNT_W-1:0] inj_d,
                           input logic [1:0] inj_a, input string req);
        for (int k = 0; k <= c0 + 3; k++) begin
            int ep, e1, e0, ec;
            ep = (fired && k >= c1 && k <= c0) ? 1 : 0;
            e1 = (fired && k == c1 && c1 <= c0) ? 1 : 0;
            e0 = (fired && k == c0 + 1) ? 1 : 0;
            ec = fired ? ((k <= c0) ? k : 0) : idle;
            chk(req, "pulse", int'(pulse), ep);
            chk(req, "start strobe", int'(irq1), e1);
            chk(req, "end strobe", int'(irq0), e0);
            chk(req, "count", int'(cnt), ec);
            if (k == inj_k) begin
                if (inj_ext) trig_in = ~trig_in;
                else begin wr_en = 1'b1; wr_addr = inj_a; wr_data = inj_d; end
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    // Change the external input and wait for the synchronized start edge.
    task automatic ext_case(input logic lvl, input bit fired, input string req);
        trig_in = lvl;
        repeat (SYNC + 1) @(negedge clk);
        observe(2, 1, fired, idle_now, -1, 1'b0, '0, 2'd0, req);
        if (fired) idle_now = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "count", int'(cnt), IDLE1);
        chk("R1", "pulse", int'(pulse), 0);
        chk("R1", "strobes", int'(irq0 | irq1), 0);
        wr(2'd0, ctl(1'b0, 1'b1, 2'd0));
        chk("R1", "trigger while disabled", int'(cnt), IDLE1);

        // R2 enabled idle holds all-ones
        wr(2'd0, ctl(1'b1, 1'b0, 2'd0));
        for (int i = 0; i < 5; i++) begin
            chk("R2", "count", int'(cnt), IDLE1);
            chk("R2", "pulse", int'(pulse), 0);
            @(negedge clk);
        end

        // R3 R4 R5 R6 sweep over compare pairs
        for (int c0 = 0; c0 <= 5; c0++) begin
            for (int c1 = 0; c1 <= 5; c1++) begin
                wr(2'd1, CNT_W'(c0));
                wr(2'd2, CNT_W'(c1));
                chk("R6", "idle before trigger", int'(cnt), idle_now);
                wr(2'd0, ctl(1'b1, 1'b1, 2'd0));
                observe(c0, c1, 1'b1, 0, -1, 1'b0, '0, 2'd0, "R4");
                idle_now = 0;
            end
        end

        // R7 triggers inside delay, inside pulse and on the closing edge
        wr(2'd1, 16'd6);
        wr(2'd2, 16'd3);
        wr(2'd0, ctl(1'b1, 1'b1, 2'd3));
        observe(6, 3, 1'b1, 0, 2, 1'b0, ctl(1'b1, 1'b1, 2'd3), 2'd0, "R7");
        wr(2'd0, ctl(1'b1, 1'b1, 2'd3));
        observe(6, 3, 1'b1, 0, 6, 1'b0, ctl(1'b1, 1'b1, 2'd3), 2'd0, "R7");
        wr(2'd0, ctl(1'b1, 1'b1, 2'd3));
        observe(6, 3, 1'b1, 0, 4, 1'b1, '0, 2'd0, "R7");
        repeat (4) @(negedge clk);
        chk("R7", "no restart after run", int'(cnt), 0);
        chk("R7", "no second pulse", int'(pulse), 0);

        // R9 compare writes during a run apply to the next run
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd1);
        wr(2'd0, ctl(1'b1, 1'b1, 2'd0));
        observe(4, 1, 1'b1, 0, 1, 1'b0, 16'd8, 2'd1, "R9");
        wr(2'd0, ctl(1'b1, 1'b1, 2'd0));
        observe(8, 1, 1'b1, 0, 3, 1'b0, 16'd5, 2'd2, "R9");
        wr(2'd0, ctl(1'b1, 1'b1, 2'd0));
        observe(8, 5, 1'b1, 0, -1, 1'b0, '0, 2'd0, "R9");

        // R8 edge select sweep on the external input
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd1);
        trig_in = 1'b0;
        wr(2'd0, ctl(1'b1, 1'b0, 2'd1));
        repeat (4) @(negedge clk);
        ext_case(1'b1, 1'b1, "R8");
        ext_case(1'b0, 1'b0, "R8");
        wr(2'd0, ctl(1'b1, 1'b0, 2'd2));
        ext_case(1'b1, 1'b0, "R8");
        ext_case(1'b0, 1'b1, "R8");
        wr(2'd0, ctl(1'b1, 1'b0, 2'd3));
        ext_case(1'b1, 1'b1, "R8");
        ext_case(1'b0, 1'b1, "R8");
        wr(2'd0, ctl(1'b1, 1'b0, 2'd0));
        ext_case(1'b1, 1'b0, "R8");
        ext_case(1'b0, 1'b0, "R8");

        // R10 disable in the middle of a pulse
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd2);
        wr(2'd0, ctl(1'b1, 1'b1, 2'd0));
        repeat (3) @(negedge clk);
        chk("R10", "pulse before disable", int'(pulse), 1);
        wr(2'd0, ctl(1'b0, 1'b0, 2'd0));
        for (int i = 0; i < 12; i++) begin
            chk("R10", "count", int'(cnt), IDLE1);
            chk("R10", "pulse", int'(pulse), 0);
            chk("R10", "strobes", int'(irq0 | irq1), 0);
            @(negedge clk);
        end

        // R11 enable with trigger in one write, and edges while disabled
        wr(2'd0, ctl(1'b1, 1'b1, 2'd0));
        observe(9, 2, 1'b0, IDLE1, -1, 1'b0, '0, 2'd0, "R11");
        wr(2'd0, ctl(1'b0, 1'b0, 2'd1));
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
        trig_in = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd0, ctl(1'b1, 1'b0, 2'd1));
        observe(9, 2, 1'b0, IDLE1, -1, 1'b0, '0, 2'd0, "R11");
        wr(2'd0, ctl(1'b1, 1'b1, 2'd1));
        observe(9, 2, 1'b1, 0, -1, 1'b0, '0, 2'd0, "R11");

        summary();
        $finish;
    end
endmodule